// File: doc/BRIEF.md
# TDM Transmit Serializer with Sample Formatting

This block takes 32-bit sample words from a one-entry holding register and sends them out, one bit per serial bit time, on a single data line. A clock unit outside the block supplies the timing: a one-cycle bit strobe per serial bit, a slot-start flag on the first bit of each slot, and the index of that slot. For every slot the block picks the sample and formats it to the configured sample size and slot length. The sample sits at the front or the back of the slot. The remaining slot bits are filled with a chosen value. Bits go out most significant first or least significant first.

Each slot can be switched off. A slot that is off drives a programmable idle level or releases the line. When an enabled slot starts and the holding register is empty, the block flags an underrun and sends zeros or the last word again. Two pairing modes let one written word serve two adjacent slots. In the compact modes a word carries two short samples, one for each slot. In mono mode the left sample is also sent in the right slot. The transmit-ready and underrun pulses are meant to drive a request or interrupt path built elsewhere.

Top module: `tx_tdm_serializer`

## Requirements
- R1: After reset, `wr_ready` is 1 and `sd_oe`, `sd_out`, `tx_ready_pulse` and `tx_underrun_pulse` are all 0.
- R2: A write is accepted when `wr_valid` and `wr_ready` are both high, and `wr_ready` then stays low while a word is held. At the strobe that starts an enabled slot that needs a new word, the held word is taken and `tx_ready_pulse` is high for one cycle, in the same cycle as the slot's first bit appears.
- R3: With `cfg_lsb_first`=0 the sample goes out most significant bit first. With 1 it goes out least significant bit first.
- R4: `cfg_data_size` selects the sample width from the low word bits: 0→32, 1→24, 2→20, 3→18, 4→16, 5→16 compact, 6→8, 7→8 compact.
- R5: `cfg_slot_len` selects the slot length in bit times: 0→8, 1→16, 2→24, 3→32. A sample longer than the slot is cut to the slot. Front placement keeps its first bits and back placement keeps its last bits.
- R6: With `cfg_left_adj`=1 the sample takes the first bit times of the slot. With 0 it takes the last bit times.
- R7: Slot bits not carrying the sample follow `cfg_fill`: 0 zeros, 1 ones, 2 copies of the sample's most significant bit, 3 copies of its least significant bit.
- R8: While `cfg_slot_off[i]`=1, slot i drives the level given by `cfg_idle_code`: 0 low, 1 high, 2 low, 3 released (`sd_oe`=0). Such a slot takes no word and raises no pulse.
- R9: If an enabled slot that needs a new word starts with the holding register empty, `tx_underrun_pulse` is high for one cycle. The slot then sends zeros (`cfg_repeat_last`=0) or the last word taken from the holding register (`cfg_repeat_last`=1). The two pulses are never high together.
- R10: In compact mode (size 5 or 7), an even slot takes a new word and sends its low half: bits 15:0 for size 5, bits 7:0 for size 7. The following odd slot sends the upper half (31:16 or 15:8) without taking a word.
- R11: With `cfg_mono`=1, an odd slot takes no word and sends the same sample as the preceding even slot.
- R12: Each bit appears on `sd_out`/`sd_oe` in the cycle after its bit strobe. The outputs hold until the next strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_valid | input | 1 | Sample word offered |
| wr_data | input | 32 | Sample word |
| wr_ready | output | 1 | Holding register empty |
| bit_tick | input | 1 | One-cycle strobe per serial bit |
| slot_start | input | 1 | With `bit_tick`: first bit of a slot |
| slot_idx | input | IDX_W | Index of the slot being started |
| cfg_slot_len | input | 2 | Slot length code |
| cfg_data_size | input | 3 | Sample size code |
| cfg_left_adj | input | 1 | Sample at start (1) or end (0) of slot |
| cfg_lsb_first | input | 1 | Bit order |
| cfg_fill | input | 2 | Fill code for unused slot bits |
| cfg_mono | input | 1 | Duplicate left sample into odd slot |
| cfg_slot_off | input | NUM_SLOTS | Per-slot disable |
| cfg_idle_code | input | 2 | Line behaviour in a disabled slot |
| cfg_repeat_last | input | 1 | Underrun sends last word instead of zeros |
| sd_out | output | 1 | Serial data |
| sd_oe | output | 1 | Serial data output enable |
| tx_ready_pulse | output | 1 | Word taken from holding register |
| tx_underrun_pulse | output | 1 | Slot began with no new word |

## Verification
The bench builds the block with the default of eight slots. Every slot index from 0 to 7 can then be started, and the even/odd pairs used by the compact and mono modes are covered. The per-slot disable bits are tested against neighbouring enabled slots. All four slot lengths can be combined with every sample size, which covers samples shorter than, equal to and longer than the slot, including truncation at either end.

// File: rtl/tx_tdm_pkg.sv
// Shared constants and decode helpers for the TDM transmit serializer.
// Assumes a fixed 32-bit sample word.
package tx_tdm_pkg;

    localparam int WORD_W = 32;

    typedef enum logic [1:0] {
        FILL_ZERO = 2'd0,
        FILL_ONE  = 2'd1,
        FILL_MSB  = 2'd2,
        FILL_LSB  = 2'd3
    } fill_e;

    // Sample width in bits for a size code.
    function automatic logic [5:0] sample_width(input logic [2:0] code);
        case (code)
            3'd0:    return 6'd32;
            3'd1:    return 6'd24;
            3'd2:    return 6'd20;
            3'd3:    return 6'd18;
            3'd4,
            3'd5:    return 6'd16;
            default: return 6'd8;
        endcase
    endfunction

    // Slot length in bit times for a slot-length code.
    function automatic logic [5:0] slot_width(input logic [1:0] code);
        case (code)
            2'd0:    return 6'd8;
            2'd1:    return 6'd16;
            2'd2:    return 6'd24;
            default: return 6'd32;
        endcase
    endfunction

    // True for the two codes that pack two samples per word.
    function automatic logic is_compact(input logic [2:0] code);
        return (code == 3'd5) || (code == 3'd7);
    endfunction

    // Word with the k lowest bits set.
    function automatic logic [WORD_W-1:0] low_ones(input logic [5:0] k);
        logic [WORD_W-1:0] m;
        for (int i = 0; i < WORD_W; i++) m[i] = (6'(i) < k);
        return m;
    endfunction

endpackage

// File: rtl/tx_hold_reg.sv
// One-entry holding register between the sample writer and the serializer.
// Assumes take is only raised by the control logic; a take with the
// register empty has no effect.
module tx_hold_reg
    import tx_tdm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [WORD_W-1:0] wr_data,
    output logic              wr_ready,
    input  logic              take,
    output logic              full,
    output logic [WORD_W-1:0] data
);

    assign wr_ready = !full;

    // Fill on an accepted write, empty when the serializer takes the word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full <= 1'b0;
            data <= '0;
        end else begin
            if (take) full <= 1'b0;
            if (wr_valid && !full) begin
                full <= 1'b1;
                data <= wr_data;
            end
        end
    end

endmodule

// File: rtl/tx_slot_fmt.sv
// Builds the bit image of one slot in time order: bit WORD_W-1 is sent
// first, and the slot covers the top slot-length bits. Purely combinational.
// Assumes the sample is right-justified in the word.
module tx_slot_fmt
    import tx_tdm_pkg::*;
(
    input  logic [WORD_W-1:0] sample,
    input  logic [2:0]        size_code,
    input  logic [1:0]        slot_code,
    input  logic              left_adj,
    input  logic              lsb_first,
    input  logic [1:0]        fill_code,
    output logic [WORD_W-1:0] img
);

    logic [5:0]        n_bits;
    logic [5:0]        l_bits;
    logic [4:0]        msb_pos;
    logic [WORD_W-1:0] rev;
    logic [WORD_W-1:0] seq;
    logic [WORD_W-1:0] slot_area;
    logic [WORD_W-1:0] front_area;
    logic [WORD_W-1:0] back_area;
    logic              fill_bit;

    // Order the sample bits, place them in the slot and add the fill.
    always_comb begin
        n_bits  = sample_width(size_code);
        l_bits  = slot_width(slot_code);
        msb_pos = 5'(n_bits - 6'd1);
        for (int i = 0; i < WORD_W; i++) rev[i] = sample[WORD_W-1-i];
        seq = lsb_first ? (rev >> (6'(WORD_W) - n_bits))
                        : (sample & low_ones(n_bits));
        case (fill_e'(fill_code))
            FILL_ZERO: fill_bit = 1'b0;
            FILL_ONE:  fill_bit = 1'b1;
            FILL_MSB:  fill_bit = sample[msb_pos];
            default:   fill_bit = sample[0];
        endcase
        slot_area  = ~low_ones(6'(WORD_W) - l_bits);
        front_area = ~low_ones(6'(WORD_W) - n_bits);
        back_area  = low_ones(n_bits) << (6'(WORD_W) - l_bits);
        if (left_adj)
            img = (seq << (6'(WORD_W) - n_bits))
                | ({WORD_W{fill_bit}} & slot_area & ~front_area);
        else
            img = (seq << (6'(WORD_W) - l_bits))
                | ({WORD_W{fill_bit}} & slot_area & ~back_area);
    end

endmodule

// File: rtl/tx_shift_out.sv
// Output shifter: loads a slot image on a slot start and sends one bit per
// bit strobe. A disabled slot drives the idle level until the next slot
// start. Assumes slot starts always come with a bit strobe.
module tx_shift_out
    import tx_tdm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              start,
    input  logic              slot_live,
    input  logic [WORD_W-1:0] img,
    input  logic              idle_level,
    input  logic              idle_drive,
    output logic              sd_out,
    output logic              sd_oe
);

    logic [WORD_W-1:0] shreg;
    logic              live;

    // Advance the line by one bit on each strobe; hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg  <= '0;
            live   <= 1'b0;
            sd_out <= 1'b0;
            sd_oe  <= 1'b0;
        end else if (tick) begin
            if (start && slot_live) begin
                sd_out <= img[WORD_W-1];
                shreg  <= img << 1;
                sd_oe  <= 1'b1;
                live   <= 1'b1;
            end else if (start) begin
                sd_out <= idle_level;
                sd_oe  <= idle_drive;
                live   <= 1'b0;
            end else if (live) begin
                sd_out <= shreg[WORD_W-1];
                shreg  <= shreg << 1;
            end
        end
    end

endmodule

// File: rtl/tx_tdm_serializer.sv
// TDM transmit serializer. Takes words from a holding register at the
// start of each enabled slot, selects the sample (compact halves, mono
// repeat), formats it to the slot and shifts it out. Assumes the config
// inputs are stable while slots run and the strobes come from a clock unit
// in the clk domain.
module tx_tdm_serializer
    import tx_tdm_pkg::*;
#(
    parameter  int NUM_SLOTS = 8,
    localparam int IDX_W     = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_valid,
    input  logic [WORD_W-1:0]    wr_data,
    output logic                 wr_ready,
    input  logic                 bit_tick,
    input  logic                 slot_start,
    input  logic [IDX_W-1:0]     slot_idx,
    input  logic [1:0]           cfg_slot_len,
    input  logic [2:0]           cfg_data_size,
    input  logic                 cfg_left_adj,
    input  logic                 cfg_lsb_first,
    input  logic [1:0]           cfg_fill,
    input  logic                 cfg_mono,
    input  logic [NUM_SLOTS-1:0] cfg_slot_off,
    input  logic [1:0]           cfg_idle_code,
    input  logic                 cfg_repeat_last,
    output logic                 sd_out,
    output logic                 sd_oe,
    output logic                 tx_ready_pulse,
    output logic                 tx_underrun_pulse
);

    logic              hold_full;
    logic [WORD_W-1:0] hold_data;
    logic [WORD_W-1:0] last_word;
    logic [WORD_W-1:0] cur_word;
    logic [WORD_W-1:0] fresh_word;
    logic [WORD_W-1:0] word_now;
    logic [WORD_W-1:0] sample;
    logic [WORD_W-1:0] img;
    logic              slot_go, slot_live, compact, paired, odd_slot;
    logic              load, take, upper_half;

    assign slot_go    = bit_tick && slot_start;
    assign slot_live  = !cfg_slot_off[slot_idx];
    assign compact    = is_compact(cfg_data_size);
    assign paired     = compact || cfg_mono;
    assign odd_slot   = slot_idx[0];
    assign load       = slot_go && slot_live && !(paired && odd_slot);
    assign take       = load && hold_full;
    assign fresh_word = hold_full ? hold_data
                                  : (cfg_repeat_last ? last_word : '0);
    assign word_now   = load ? fresh_word : cur_word;
    assign upper_half = odd_slot && !cfg_mono;

    // Pick the sample for this slot out of the current word.
    always_comb begin
        if (!compact)
            sample = word_now;
        else if (cfg_data_size == 3'd5)
            sample = {16'b0, upper_half ? word_now[31:16] : word_now[15:0]};
        else
            sample = {24'b0, upper_half ? word_now[15:8] : word_now[7:0]};
    end

    // Remember the word in use and the last word taken; raise the pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_word          <= '0;
            last_word         <= '0;
            tx_ready_pulse    <= 1'b0;
            tx_underrun_pulse <= 1'b0;
        end else begin
            tx_ready_pulse    <= take;
            tx_underrun_pulse <= load && !hold_full;
            if (load) cur_word  <= fresh_word;
            if (take) last_word <= hold_data;
        end
    end

    tx_hold_reg u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_valid (wr_valid),
        .wr_data  (wr_data),
        .wr_ready (wr_ready),
        .take     (take),
        .full     (hold_full),
        .data     (hold_data)
    );

    tx_slot_fmt u_fmt (
        .sample    (sample),
        .size_code (cfg_data_size),
        .slot_code (cfg_slot_len),
        .left_adj  (cfg_left_adj),
        .lsb_first (cfg_lsb_first),
        .fill_code (cfg_fill),
        .img       (img)
    );

    tx_shift_out u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (bit_tick),
        .start      (slot_start),
        .slot_live  (slot_live),
        .img        (img),
        .idle_level (cfg_idle_code == 2'd1),
        .idle_drive (cfg_idle_code != 2'd3),
        .sd_out     (sd_out),
        .sd_oe      (sd_oe)
    );

endmodule

// File: rtl/tx_tdm_checker.sv
// Port-level properties of the TDM transmit serializer, bound to the top.
module tx_tdm_checker #(
    parameter  int NUM_SLOTS = 8,
    localparam int IDX_W     = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 wr_valid,
    input logic                 wr_ready,
    input logic                 bit_tick,
    input logic                 slot_start,
    input logic [IDX_W-1:0]     slot_idx,
    input logic [NUM_SLOTS-1:0] cfg_slot_off,
    input logic [1:0]           cfg_idle_code,
    input logic                 sd_out,
    input logic                 sd_oe,
    input logic                 tx_ready_pulse,
    input logic                 tx_underrun_pulse
);

    logic off_start;
    assign off_start = bit_tick && slot_start && cfg_slot_off[slot_idx];

    assert_hold_blocks_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_ready) |=> !wr_ready);

    assert_ready_at_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ready_pulse |-> $past(bit_tick && slot_start));

    assert_pulse_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_ready_pulse && tx_underrun_pulse));

    assert_line_held_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(bit_tick) |-> ($stable(sd_out) && $stable(sd_oe)));

    assert_released_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (off_start && cfg_idle_code == 2'd3) |=> !sd_oe);

    assert_idle_silent_R8: assert property (@(posedge clk) disable iff (!rst_n)
        off_start |=> (!tx_ready_pulse && !tx_underrun_pulse));

endmodule

bind tx_tdm_serializer tx_tdm_checker #(.NUM_SLOTS(NUM_SLOTS)) u_chk (
    .clk               (clk),
    .rst_n             (rst_n),
    .wr_valid          (wr_valid),
    .wr_ready          (wr_ready),
    .bit_tick          (bit_tick),
    .slot_start        (slot_start),
    .slot_idx          (slot_idx),
    .cfg_slot_off      (cfg_slot_off),
    .cfg_idle_code     (cfg_idle_code),
    .sd_out            (sd_out),
    .sd_oe             (sd_oe),
    .tx_ready_pulse    (tx_ready_pulse),
    .tx_underrun_pulse (tx_underrun_pulse)
);

// File: tb/tb_tx_tdm_serializer.sv
// Scoreboard bench: slot tasks push the expected line bits into a queue and
// a monitor pops and compares one item after every bit strobe.
module tb_tx_tdm_serializer;

    localparam int NS = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_valid = 1'b0;
    logic [31:0] wr_data = '0;
    logic        wr_ready;
    logic        bit_tick = 1'b0;
    logic        slot_start = 1'b0;
    logic [2:0]  slot_idx = '0;
    logic [1:0]  cfg_slot_len = 2'd3;
    logic [2:0]  cfg_data_size = 3'd0;
    logic        cfg_left_adj = 1'b0;
    logic        cfg_lsb_first = 1'b0;
    logic [1:0]  cfg_fill = 2'd0;
    logic        cfg_mono = 1'b0;
    logic [NS-1:0] cfg_slot_off = '0;
    logic [1:0]  cfg_idle_code = 2'd0;
    logic        cfg_repeat_last = 1'b0;
    logic        sd_out, sd_oe, tx_ready_pulse, tx_underrun_pulse;

    always #5 clk = ~clk;

    tx_tdm_serializer #(.NUM_SLOTS(NS)) dut (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
        .wr_ready(wr_ready), .bit_tick(bit_tick), .slot_start(slot_start),
        .slot_idx(slot_idx), .cfg_slot_len(cfg_slot_len),
        .cfg_data_size(cfg_data_size), .cfg_left_adj(cfg_left_adj),
        .cfg_lsb_first(cfg_lsb_first), .cfg_fill(cfg_fill),
        .cfg_mono(cfg_mono), .cfg_slot_off(cfg_slot_off),
        .cfg_idle_code(cfg_idle_code), .cfg_repeat_last(cfg_repeat_last),
        .sd_out(sd_out), .sd_oe(sd_oe), .tx_ready_pulse(tx_ready_pulse),
        .tx_underrun_pulse(tx_underrun_pulse)
    );

    typedef struct {
        bit    d;
        bit    oe;
        bit    rdy;
        bit    ur;
        string tag;
    } item_t;

    item_t       exp_q[$];
    int          n_checks = 0;
    int          n_fails  = 0;
    bit          finished = 0;
    logic        tick_d = 1'b0;

    // Reference model state.
    bit          m_full = 0;
    logic [31:0] m_hold = '0;
    logic [31:0] m_last = '0;
    logic [31:0] m_cur  = '0;

    task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int width_of(logic [2:0] c);
        int w [8] = '{32, 24, 20, 18, 16, 16, 8, 8};
        return w[c];
    endfunction

    // Expected bit at time t of a slot, straight from R3, R5, R6 and R7.
    function automatic bit line_bit(logic [31:0] s, int n, int len, int t);
        int start_t, q;
        bit f;
        case (cfg_fill)
            2'd0:    f = 1'b0;
            2'd1:    f = 1'b1;
            2'd2:    f = s[n-1];
            default: f = s[0];
        endcase
        start_t = cfg_left_adj ? 0 : len - n;
        q = t - start_t;
        if (q >= 0 && q < n) return cfg_lsb_first ? s[q] : s[n-1-q];
        return f;
    endfunction

    // Monitor: note strobes at the edge, compare away from it.
    always @(posedge clk) tick_d <= bit_tick;

    always @(negedge clk) begin
        if (rst_n && tick_d) begin
            if (exp_q.size() == 0) begin
                check(0, "R12 unexpected bit", 32'(sd_out), 0);
            end else begin
                item_t it;
                it = exp_q.pop_front();
                check(sd_oe == it.oe, {it.tag, " oe"}, 32'(sd_oe), 32'(it.oe));
                if (it.oe)
                    check(sd_out == it.d, {it.tag, " data"}, 32'(sd_out), 32'(it.d));
                check(tx_ready_pulse == it.rdy, "R2 ready pulse",
                      32'(tx_ready_pulse), 32'(it.rdy));
                check(tx_underrun_pulse == it.ur, "R9 underrun pulse",
                      32'(tx_underrun_pulse), 32'(it.ur));
            end
        end
    end

    task automatic put_word(logic [31:0] w);
        @(negedge clk);
        check(wr_ready == 1'b1, "R2 ready before write", 32'(wr_ready), 1);
        wr_valid = 1'b1;
        wr_data  = w;
        @(negedge clk);
        wr_valid = 1'b0;
        check(wr_ready == 1'b0, "R2 ready low while held", 32'(wr_ready), 0);
        m_full = 1;
        m_hold = w;
    endtask

    // Driver: model one slot, push its bits, then strobe it through.
    task automatic run_slot(int idx, string tag);
        int  len, n;
        bit  rdy, ur, cmp, odd;
        logic [31:0] s;
        len = 8 * (int'(cfg_slot_len) + 1);
        n   = width_of(cfg_data_size);
        if (cfg_slot_off[idx]) begin
            for (int t = 0; t < len; t++)
                exp_q.push_back('{d: (cfg_idle_code == 2'd1),
                                  oe: (cfg_idle_code != 2'd3),
                                  rdy: 0, ur: 0, tag: tag});
        end else begin
            cmp = (cfg_data_size == 3'd5) || (cfg_data_size == 3'd7);
            odd = (idx % 2) == 1;
            rdy = 0;
            ur  = 0;
            if (!((cmp || cfg_mono) && odd)) begin
                if (m_full) begin
                    m_cur = m_hold; m_last = m_hold; m_full = 0; rdy = 1;
                end else begin
                    ur = 1;
                    m_cur = cfg_repeat_last ? m_last : 32'h0;
                end
            end
            s = m_cur;
            if (cmp) begin
                if (cfg_data_size == 3'd5)
                    s = (odd && !cfg_mono) ? (m_cur >> 16) : m_cur;
                else
                    s = (odd && !cfg_mono) ? (m_cur >> 8) : m_cur;
            end
            for (int t = 0; t < len; t++)
                exp_q.push_back('{d: line_bit(s, n, len, t), oe: 1'b1,
                                  rdy: (t == 0) ? rdy : 1'b0,
                                  ur: (t == 0) ? ur : 1'b0, tag: tag});
        end
        for (int t = 0; t < len; t++) begin
            @(negedge clk);
            bit_tick   = 1'b1;
            slot_start = (t == 0);
            slot_idx   = 3'(idx);
            @(negedge clk);
            bit_tick   = 1'b0;
            slot_start = 1'b0;
        end
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: run did not complete");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        logic held_out, held_oe;
        repeat (4) @(negedge clk);
        check(wr_ready == 1'b1, "R1 wr_ready", 32'(wr_ready), 1);
        check(sd_oe == 1'b0, "R1 sd_oe", 32'(sd_oe), 0);
        check(sd_out == 1'b0, "R1 sd_out", 32'(sd_out), 0);
        check(!tx_ready_pulse && !tx_underrun_pulse, "R1 pulses",
              32'({tx_ready_pulse, tx_underrun_pulse}), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R3 MSB first, 32-bit sample in 32-bit slot
        put_word(32'hA5C3_0F1E);
        run_slot(0, "R3 msb first");
        check(wr_ready == 1'b1, "R2 ready after take", 32'(wr_ready), 1);

        // R3 LSB first
        cfg_lsb_first = 1'b1;
        put_word(32'h1234_5678);
        run_slot(1, "R3 lsb first");
        cfg_lsb_first = 1'b0;

        // R4 R6 R7 16-bit sample, front placement, fill ones
        cfg_data_size = 3'd4; cfg_left_adj = 1'b1; cfg_fill = 2'd1;
        put_word(32'hFFFF_8421);
        run_slot(2, "R6 R7 front fill ones");
        // R6 R7 back placement, fill with sample MSB
        cfg_left_adj = 1'b0; cfg_fill = 2'd2;
        put_word(32'h0000_9001);
        run_slot(3, "R6 R7 back fill msb");
        // R7 fill with sample LSB, LSB first
        cfg_fill = 2'd3; cfg_lsb_first = 1'b1;
        put_word(32'h0000_4003);
        run_slot(4, "R7 fill lsb");
        cfg_lsb_first = 1'b0;

        // R5 24-bit sample cut to a 16-bit slot, both placements
        cfg_slot_len = 2'd1; cfg_data_size = 3'd1; cfg_left_adj = 1'b1;
        put_word(32'h00AB_CDEF);
        run_slot(5, "R5 cut front");
        cfg_left_adj = 1'b0;
        put_word(32'h0012_3456);
        run_slot(6, "R5 cut back");

        // R4 20-bit and 18-bit samples in 24-bit slot, 8-bit in 8-bit slot
        cfg_slot_len = 2'd2; cfg_data_size = 3'd2; cfg_fill = 2'd0;
        put_word(32'hFFF9_6A5C);
        run_slot(7, "R4 size 20");
        cfg_data_size = 3'd3; cfg_left_adj = 1'b1; cfg_fill = 2'd1;
        put_word(32'h0002_1357);
        run_slot(0, "R4 size 18");
        cfg_slot_len = 2'd0; cfg_data_size = 3'd6;
        put_word(32'h1234_56B7);
        run_slot(1, "R4 size 8");

        // R8 disabled slot, every idle code, word stays held
        cfg_slot_len = 2'd1; cfg_data_size = 3'd4; cfg_left_adj = 1'b0;
        cfg_fill = 2'd0; cfg_slot_off = 8'b0000_0100;
        put_word(32'h0000_C0DE);
        for (int c = 0; c < 4; c++) begin
            cfg_idle_code = 2'(c);
            run_slot(2, "R8 idle slot");
            check(wr_ready == 1'b0, "R8 word not taken", 32'(wr_ready), 0);
        end
        cfg_idle_code = 2'd0;
        run_slot(3, "R8 enabled neighbour");
        cfg_slot_off = '0;

        // R12 line holds with no strobes
        held_out = sd_out; held_oe = sd_oe;
        repeat (5) @(negedge clk);
        check(sd_out == held_out && sd_oe == held_oe, "R12 hold",
              32'({sd_out, sd_oe}), 32'({held_out, held_oe}));

        // R9 underrun: zeros, then repeat of last word
        run_slot(4, "R9 underrun zeros");
        cfg_repeat_last = 1'b1;
        run_slot(5, "R9 underrun repeat");
        cfg_repeat_last = 1'b0;

        // R10 compact 16 and compact 8
        cfg_data_size = 3'd5;
        put_word(32'hBEEF_1234);
        run_slot(0, "R10 compact16 low");
        run_slot(1, "R10 compact16 high");
        cfg_slot_len = 2'd0; cfg_data_size = 3'd7;
        put_word(32'h0000_5AC3);
        run_slot(2, "R10 compact8 low");
        run_slot(3, "R10 compact8 high");

        // R11 mono: odd slot repeats the even slot's sample
        cfg_slot_len = 2'd1; cfg_data_size = 3'd4; cfg_mono = 1'b1;
        put_word(32'h0000_F00D);
        run_slot(4, "R11 mono left");
        run_slot(5, "R11 mono right");
        cfg_mono = 1'b0;

        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "R12 all bits seen", 32'(exp_q.size()), 0);
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule